// File: doc/BRIEF.md
# Interpolating Multi-Table NCO

This block is a numerically controlled oscillator. A sample strobe advances it. It keeps a phase accumulator, and the upper accumulator bits form one read address that every waveform table shares. On each strobe the block produces one signed sample per table from the phase held before that strobe. It then adds the frequency control word to the accumulator.

A build-time switch selects one of two output modes. In the first, each output is the table entry at the address. In the second, each output is a linear interpolation between that entry and the next one, weighted by the low accumulator bits. The next-entry lookup wraps from the last entry back to entry 0.

The table contents are fixed when the design is built. They are computed by a constant function that gives a quantized parabolic approximation of a sine wave, with each table shifted by a further quarter period. For a nominal sample rate fs, a tone at frequency f needs the control word round(f / fs · 2^PHASE_W). The frequency step is fs / 2^PHASE_W. The usual setting is fs = 60 kHz with a 24-bit phase.

Top module: `nco_multi_table`

## Requirements
- R1: While reset is high on a clock edge, the phase becomes 0, `valid_o` goes low and every sample becomes 0.
- R2: `valid_o` is high in the cycle after each cycle with `strobe_i` high, and low in every other cycle.
- R3: The samples produced by a strobe come from the phase held before that strobe, so the first strobe after reset reads phase 0.
- R4: Each strobe adds `fcw_i` to the phase modulo 2^PHASE_W. The phase does not change in a cycle without a strobe.
- R5: The read address is the top ADDR_W phase bits, and the same address drives every table. Table t appears on `samples_o[t*SAMP_W +: SAMP_W]` in two's complement.
- R6: Entry k of table t is defined as follows, with N = 2^ADDR_W, H = N/2, A = 2^(SAMP_W-1) − 1 and j = (k + t·N/4) mod N. With p = j mod H, the entry is floor(4·A·p·(H−p)/H²), negated when j ≥ H. With the defaults, table 0 entry 0 is 0 and table 1 entry 0 is 32767.
- R7: With INTERP = 0, each sample equals the table entry at the address.
- R8: With INTERP = 1, each sample is s0 + floor((s1 − s0)·frac / 2^F). Here F = PHASE_W − ADDR_W, frac is the low F phase bits, s0 is the entry at the address and s1 is the entry at address + 1. The product is kept at full precision, and the result saturates to the SAMP_W range.
- R9: When the address is the last entry (N − 1), the s1 lookup uses entry 0.
- R10: A strobe with `fcw_i` = 0 leaves the phase unchanged, so every later strobe gives the same samples.
- R11: The samples change only in the cycle after a strobe, and keep their value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Sample enable: emit samples, then advance the phase |
| fcw_i | input | PHASE_W | Frequency control word added to the phase per strobe |
| samples_o | output | NUM_TAB*SAMP_W | One signed sample per table, table 0 in the low bits |
| valid_o | output | 1 | High for one cycle after each strobe |

## Verification
The hardest situation to reach is the end of the table. The phase must sit in the last address slot with a nonzero fraction, so that interpolation has to reach back to entry 0. The bench gets there directly: from reset it applies a control word of all ones, which places the phase at the top of the range with a maximal fraction. It then steps once more to check the accumulator overflow back to zero. Other control words, some with fractions that are not round numbers, move the phase through most slots while a model in the bench tracks it.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int DEF_PHASE_W = 24;
    localparam int DEF_ADDR_W  = 6;
    localparam int DEF_SAMP_W  = 16;
    localparam int DEF_NUM_TAB = 2;

    // Quantized parabolic sine approximation, shifted by tab quarter periods.
    function automatic longint wave_value(input int tab, input int k,
                                          input int addr_w, input int samp_w);
        longint n, half, quarter, amp, j, p, mag;
        n       = longint'(1) << addr_w;
        half    = n / 2;
        quarter = n / 4;
        amp     = (longint'(1) << (samp_w - 1)) - 1;
        j       = (longint'(k) + longint'(tab) * quarter) % n;
        p       = (j < half) ? j : j - half;
        mag     = (4 * amp * p * (half - p)) / (half * half);
        return (j < half) ? mag : -mag;
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = nco_pkg::DEF_PHASE_W,
    parameter int ADDR_W  = nco_pkg::DEF_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        strobe_i,
    input  logic [PHASE_W-1:0]          fcw_i,
    output logic [ADDR_W-1:0]           addr_o,
    output logic [ADDR_W-1:0]           addr_next_o,
    output logic [PHASE_W-ADDR_W-1:0]   frac_o
);
    localparam int FRAC_W = PHASE_W - ADDR_W;

    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (strobe_i) begin
            acc_q <= acc_q + fcw_i;
        end
    end

    assign addr_o      = acc_q[PHASE_W-1 -: ADDR_W];
    assign addr_next_o = addr_o + ADDR_W'(1);
    assign frac_o      = acc_q[FRAC_W-1:0];

    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(acc_q));

    // R10
    zero_fcw_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && fcw_i == '0) |=> $stable(acc_q));

endmodule

// File: rtl/nco_wave_rom.sv
module nco_wave_rom #(
    parameter int TAB_IDX = 0,
    parameter int ADDR_W  = nco_pkg::DEF_ADDR_W,
    parameter int SAMP_W  = nco_pkg::DEF_SAMP_W
) (
    input  logic [ADDR_W-1:0]         addr_a_i,
    input  logic [ADDR_W-1:0]         addr_b_i,
    output logic signed [SAMP_W-1:0]  rd_a_o,
    output logic signed [SAMP_W-1:0]  rd_b_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic signed [SAMP_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign mem[i] = SAMP_W'(nco_pkg::wave_value(TAB_IDX, i, ADDR_W, SAMP_W));
    end

    assign rd_a_o = mem[addr_a_i];
    assign rd_b_o = mem[addr_b_i];

endmodule

// File: rtl/nco_lerp.sv
module nco_lerp #(
    parameter int SAMP_W = nco_pkg::DEF_SAMP_W,
    parameter int FRAC_W = nco_pkg::DEF_PHASE_W - nco_pkg::DEF_ADDR_W
) (
    input  logic signed [SAMP_W-1:0] s0_i,
    input  logic signed [SAMP_W-1:0] s1_i,
    input  logic [FRAC_W-1:0]        frac_i,
    output logic signed [SAMP_W-1:0] y_o
);
    localparam int PW = SAMP_W + FRAC_W + 2;
    localparam logic signed [PW-1:0] HI = {{(FRAC_W+3){1'b0}}, {(SAMP_W-1){1'b1}}};
    localparam logic signed [PW-1:0] LO = ~HI;

    logic signed [PW-1:0] diff_w, frac_w, prod_w, step_w, sum_w;

    always_comb begin
        diff_w = PW'(s1_i) - PW'(s0_i);
        frac_w = {{(SAMP_W+2){1'b0}}, frac_i};
        prod_w = diff_w * frac_w;
        step_w = prod_w >>> FRAC_W;
        sum_w  = PW'(s0_i) + step_w;
        if (sum_w > HI)      y_o = HI[SAMP_W-1:0];
        else if (sum_w < LO) y_o = LO[SAMP_W-1:0];
        else                 y_o = sum_w[SAMP_W-1:0];
    end

    always_comb begin
        if (!$isunknown({s0_i, s1_i, frac_i})) begin
            // R8
            interp_bounds_chk: assert ((y_o >= s0_i && y_o <= s1_i) ||
                                       (y_o <= s0_i && y_o >= s1_i));
        end
    end

endmodule

// File: rtl/nco_multi_table.sv
module nco_multi_table #(
    parameter int PHASE_W = nco_pkg::DEF_PHASE_W,
    parameter int ADDR_W  = nco_pkg::DEF_ADDR_W,
    parameter int SAMP_W  = nco_pkg::DEF_SAMP_W,
    parameter int NUM_TAB = nco_pkg::DEF_NUM_TAB,
    parameter bit INTERP  = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        strobe_i,
    input  logic [PHASE_W-1:0]          fcw_i,
    output logic [NUM_TAB*SAMP_W-1:0]   samples_o,
    output logic                        valid_o
);
    localparam int FRAC_W = PHASE_W - ADDR_W;

    logic [ADDR_W-1:0]        addr, addr_next;
    logic [FRAC_W-1:0]        frac;
    logic signed [SAMP_W-1:0] samp_d [NUM_TAB];
    logic signed [SAMP_W-1:0] samp_q [NUM_TAB];
    logic                     valid_q;

    nco_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) i_phase (
        .clk         (clk),
        .rst         (rst),
        .strobe_i    (strobe_i),
        .fcw_i       (fcw_i),
        .addr_o      (addr),
        .addr_next_o (addr_next),
        .frac_o      (frac)
    );

    for (genvar t = 0; t < NUM_TAB; t++) begin : g_tab
        logic signed [SAMP_W-1:0] s0, s1;

        nco_wave_rom #(.TAB_IDX(t), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) i_rom (
            .addr_a_i (addr),
            .addr_b_i (addr_next),
            .rd_a_o   (s0),
            .rd_b_o   (s1)
        );

        if (INTERP) begin : g_interp
            nco_lerp #(.SAMP_W(SAMP_W), .FRAC_W(FRAC_W)) i_lerp (
                .s0_i   (s0),
                .s1_i   (s1),
                .frac_i (frac),
                .y_o    (samp_d[t])
            );
        end else begin : g_direct
            assign samp_d[t] = s0;
        end

        assign samples_o[t*SAMP_W +: SAMP_W] = samp_q[t];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            for (int t = 0; t < NUM_TAB; t++) samp_q[t] <= '0;
        end else begin
            valid_q <= strobe_i;
            if (strobe_i) begin
                for (int t = 0; t < NUM_TAB; t++) samp_q[t] <= samp_d[t];
            end
        end
    end

    assign valid_o = valid_q;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> valid_o);

    // R2
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(strobe_i));

    // R11
    sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(samples_o));

endmodule

// File: tb/test_nco_multi_table.sv
module test_nco_multi_table;

    localparam int PW = 24;
    localparam int AW = 6;
    localparam int SW = 16;
    localparam int NT = 2;
    localparam int FW = PW - AW;
    localparam int NV = 5;

    localparam logic [PW-1:0] VEC_FCW   [NV] = '{24'h040000, 24'h012345, 24'h7FFFFF,
                                                 24'h0ABCDE, 24'h000101};
    localparam int            VEC_STEPS [NV] = '{6, 7, 5, 6, 4};

    logic clk = 1'b0;
    logic rst;
    logic strobe;
    logic [PW-1:0] fcw;
    logic [NT*SW-1:0] smp_i, smp_d;
    logic val_i, val_d;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    logic [PW-1:0] model_acc;

    always #2 clk = ~clk;

    nco_multi_table #(.PHASE_W(PW), .ADDR_W(AW), .SAMP_W(SW), .NUM_TAB(NT), .INTERP(1'b1))
    i_nco_multi_table (
        .clk(clk), .rst(rst), .strobe_i(strobe), .fcw_i(fcw),
        .samples_o(smp_i), .valid_o(val_i)
    );

    nco_multi_table #(.PHASE_W(PW), .ADDR_W(AW), .SAMP_W(SW), .NUM_TAB(NT), .INTERP(1'b0))
    i_nco_direct (
        .clk(clk), .rst(rst), .strobe_i(strobe), .fcw_i(fcw),
        .samples_o(smp_d), .valid_o(val_d)
    );

    // R6 table definition, written from the requirement
    function automatic int ref_entry(input int tab, input int k);
        longint n = 64, h = 32, a = 32767;
        longint j = (longint'(k) + longint'(tab) * 16) % n;
        longint p = (j < h) ? j : j - h;
        longint m = (4 * a * p * (h - p)) / (h * h);
        return int'((j < h) ? m : -m);
    endfunction

    function automatic int ref_out(input int tab, input logic [PW-1:0] ph, input bit interp);
        int idx = int'(ph[PW-1:FW]);
        longint f = longint'(ph[FW-1:0]);
        longint s0 = ref_entry(tab, idx);
        longint s1 = ref_entry(tab, (idx + 1) % 64);
        longint r;
        if (!interp) return int'(s0);
        r = s0 + (((s1 - s0) * f) >>> FW);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int lane(input logic [NT*SW-1:0] v, input int t);
        return int'($signed(v[t*SW +: SW]));
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_step(input logic [PW-1:0] f, input string ctx);
        int ei [NT];
        int ed [NT];
        for (int t = 0; t < NT; t++) begin
            ei[t] = ref_out(t, model_acc, 1'b1);
            ed[t] = ref_out(t, model_acc, 1'b0);
        end
        fcw = f;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check("R2", "valid after strobe (interp)", int'(val_i), 1);
        check("R2", "valid after strobe (direct)", int'(val_d), 1);
        for (int t = 0; t < NT; t++) begin
            check("R8", {ctx, " interp sample"}, lane(smp_i, t), ei[t]);
            check("R7", {ctx, " direct sample"}, lane(smp_d, t), ed[t]);
        end
        model_acc = model_acc + f;
        @(negedge clk);
        check("R2", "valid low without strobe", int'(val_i), 0);
        for (int t = 0; t < NT; t++) begin
            check("R11", "interp held", lane(smp_i, t), ei[t]);
            check("R11", "direct held", lane(smp_d, t), ed[t]);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_acc = '0;
        // R1
        check("R1", "valid after reset", int'(val_i) + int'(val_d), 0);
        for (int t = 0; t < NT; t++) begin
            check("R1", "interp sample after reset", lane(smp_i, t), 0);
            check("R1", "direct sample after reset", lane(smp_d, t), 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int held [NT];
        rst = 1'b1;
        strobe = 1'b0;
        fcw = '0;
        model_acc = '0;
        repeat (3) @(negedge clk);
        do_reset();

        // R3 R6: first strobe reads phase 0: table 0 gives 0, table 1 gives 32767
        do_step(24'h040000, "R3");
        check("R6", "table 0 entry 0", lane(smp_d, 0), 0);
        check("R6", "table 1 entry 0", lane(smp_d, 1), 32767);

        // Vector walk: R5 for whole-entry steps, R4 for phase accumulation
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < VEC_STEPS[v]; s++) begin
                do_step(VEC_FCW[v], (v == 0) ? "R5" : "R4");
            end
        end

        // R10: zero control word holds the output
        for (int t = 0; t < NT; t++) held[t] = lane(smp_i, t);
        do_step(24'h000000, "R10");
        do_step(24'h000000, "R10");
        for (int t = 0; t < NT; t++) begin
            check("R10", "unchanged with zero word", lane(smp_i, t), ref_out(t, model_acc, 1'b1));
        end
        do_step(24'h000000, "R10");
        for (int t = 0; t < NT; t++) begin
            check("R10", "repeat equals earlier", lane(smp_i, t), ref_out(t, model_acc, 1'b1));
        end
        for (int t = 0; t < NT; t++) held[t] = lane(smp_i, t);
        do_step(24'h000000, "R10");
        for (int t = 0; t < NT; t++) check("R10", "same as previous", lane(smp_i, t), held[t]);

        // R9: last slot with maximal fraction reaches back to entry 0
        do_reset();
        do_step(24'hFFFFFF, "R3");
        do_step(24'h000000, "R9");
        check("R9", "table 0 interp at top", lane(smp_i, 0),
              ref_entry(0, 63) + int'(((longint'(ref_entry(0, 0) - ref_entry(0, 63)) * 262143) >>> 18)));
        check("R9", "table 1 direct at top", lane(smp_d, 1), ref_entry(1, 63));
        // R4: overflow back to phase 0
        do_step(24'h000001, "R4");
        do_step(24'h000000, "R4");
        check("R4", "wrapped phase table 1", lane(smp_i, 1), 32767);
        check("R4", "wrapped phase table 0", lane(smp_i, 0), 0);

        // R1 R3: reset in the middle of a run
        do_step(24'h123456, "R4");
        do_step(24'h123456, "R4");
        do_reset();
        do_step(24'h020000, "R3");
        check("R3", "phase zero after mid reset", lane(smp_i, 1), 32767);

        finish_run();
    end

endmodule